// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns local-bus addresses into PCI bus addresses through a small set of programmable windows. Each window has two 32-bit registers: a base word holding the local start address, a size code and an enable bit, and a map word holding the PCI start address, a cycle type and a flag that says how PCI address bits 1:0 are formed. Software loads these words through a simple write port. It then presents local addresses on a request input. One cycle later the block returns the translated address, the cycle type, the index of the window that was used and a hit flag.

Windows are allowed to overlap. The lowest-numbered enabled window that covers an address always wins. This lets software make window 0 larger so that it hides window 1. Window 1 can then be pointed at configuration space while ordinary memory traffic still passes through window 0. The last window serves PCI I/O space and always spans 16 MB, whatever its size field holds.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset every window is disabled and `rsp_valid` is low. A lookup made before any register write returns a miss.
- R2: A lookup presented with `req_valid` high produces `rsp_valid` high exactly one clock later. On a hit, `rsp_addr` bits 31:20 take the map word's bits 31:20 above the window-size boundary and the local address bits below it. `rsp_addr` bits 19:2 always equal the local address bits 19:2.
- R3: When several enabled windows cover an address, the one with the lowest index is used. `rsp_win` reports that index.
- R4: A window whose base word bit 0 (enable) is 0 never matches.
- R5: Base word bits 7:4 hold a size code c, and the window then spans 1 MB << c, so codes 4, 8 and 9 give 16 MB, 256 MB and 512 MB. Base word bits 31:20 give the start address. Base bits below the window size are ignored, and addresses from start up to start + size - 1 match.
- R6: The highest-numbered window (index 2) always spans 16 MB, whatever its size code.
- R7: Map word bits 3:1 are returned on `rsp_type` on a hit. The codes are 001 = I/O, 011 = memory, 101 = configuration and 111 = memory-multiple.
- R8: Map word bit 0 set passes local address bits 1:0 through to `rsp_addr`. When the bit is clear, those address bits are forced to 0.
- R9: A lookup that matches no window gives `rsp_hit` = 0, with `rsp_addr`, `rsp_type` and `rsp_win` all 0.
- R10: A register write takes effect from the next lookup. A lookup presented in the same cycle as a write still uses the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 2 | Window index for the write |
| wr_map | input | 1 | 1 writes the map word, 0 writes the base word |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | 1 when a window matched |
| rsp_win | output | 2 | Index of the window that matched |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_type | output | 3 | Cycle type of the window that matched |

## Verification
Lookups are made first with no window programmed, then with three disjoint windows at their interior points, their last addresses and just beyond them. These patterns separate a correct range check from an off-by-one error or a wrongly used size code. The I/O window is given a large size code and probed just past 16 MB, which shows whether the fixed size is enforced.

Window 0 is then enlarged over window 1, and window 1 is moved to configuration space. This separates lowest-index priority from last-match or highest-index priority. A disable is written in the same cycle as a lookup and followed by a repeat of that lookup. This tells an old-contents result apart from a write that reaches the comparators too early, and it confirms that a disabled window no longer matches. The low-bit pass flag is tried with both values, using addresses whose bits 1:0 are nonzero.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int SZ_W        = 4;
  localparam int BASE_EN_BIT = 0;
  localparam int BASE_SZ_LSB = 4;
  localparam int MAP_LOW_BIT = 0;
  localparam int MAP_TY_LSB  = 1;
  localparam int TY_W        = 3;

  typedef enum logic [TY_W-1:0] {
    CYC_IO   = 3'b001,
    CYC_MEM  = 3'b011,
    CYC_CFG  = 3'b101,
    CYC_MEMM = 3'b111
  } cyc_t;
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
  import xlat_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int GRAN_W  = 20,
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [WIN_W-1:0]                   wr_win,
  input  logic                               wr_map,
  input  logic [ADDR_W-1:0]                  wr_data,
  output logic [NUM_WIN-1:0]                 en_o,
  output logic [NUM_WIN-1:0][SZ_W-1:0]       sz_o,
  output logic [NUM_WIN-1:0][ADDR_W-GRAN_W-1:0] base_o,
  output logic [NUM_WIN-1:0][ADDR_W-GRAN_W-1:0] mhi_o,
  output logic [NUM_WIN-1:0][TY_W-1:0]       mty_o,
  output logic [NUM_WIN-1:0]                 mlow_o
);
  localparam int HI_W = ADDR_W - GRAN_W;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [ADDR_W-1:0] base_q, map_q;
    logic              sel;
    assign sel = wr_en && (wr_win == WIN_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        map_q  <= '0;
      end else if (sel) begin
        if (wr_map) map_q  <= wr_data;
        else        base_q <= wr_data;
      end
    end

    assign en_o[i]   = base_q[BASE_EN_BIT];
    assign sz_o[i]   = base_q[BASE_SZ_LSB +: SZ_W];
    assign base_o[i] = base_q[ADDR_W-1 -: HI_W];
    assign mhi_o[i]  = map_q[ADDR_W-1 -: HI_W];
    assign mty_o[i]  = map_q[MAP_TY_LSB +: TY_W];
    assign mlow_o[i] = map_q[MAP_LOW_BIT];
  end
endmodule

// File: rtl/xlat_match.sv
module xlat_match
  import xlat_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          GRAN_W     = 20,
  parameter bit          FIXED      = 1'b0,
  parameter int          FIXED_CODE = 4
) (
  input  logic                      en,
  input  logic [SZ_W-1:0]           sz,
  input  logic [ADDR_W-GRAN_W-1:0]  base_hi,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit,
  output logic [ADDR_W-GRAN_W-1:0]  keep_mask
);
  localparam int HI_W = ADDR_W - GRAN_W;

  logic [SZ_W-1:0] code;
  assign code = FIXED ? SZ_W'(FIXED_CODE) : sz;

  always_comb begin
    if (int'(code) >= HI_W) keep_mask = '0;
    else keep_mask = ~((HI_W'(1) << code) - HI_W'(1));
  end

  assign hit = en && ((addr[ADDR_W-1 -: HI_W] & keep_mask) == (base_hi & keep_mask));
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import xlat_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int GRAN_W  = 20,
  parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [NUM_WIN-1:0]                    match_vec,
  input  logic [NUM_WIN-1:0]                    en_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-GRAN_W-1:0] keep_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-GRAN_W-1:0] mhi_vec,
  input  logic [NUM_WIN-1:0][TY_W-1:0]          mty_vec,
  input  logic [NUM_WIN-1:0]                    mlow_vec,
  output logic                                  rsp_valid,
  output logic                                  rsp_hit,
  output logic [WIN_W-1:0]                      rsp_win,
  output logic [ADDR_W-1:0]                     rsp_addr,
  output logic [TY_W-1:0]                       rsp_type
);
  localparam int HI_W = ADDR_W - GRAN_W;

  logic             any_hit;
  logic [WIN_W-1:0] sel;
  logic [ADDR_W-1:0] xaddr;
  logic [HI_W-1:0]  hi_part;

  always_comb begin
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_vec[i]) sel = WIN_W'(i);
    end
  end

  assign any_hit = |match_vec;
  assign hi_part = (mhi_vec[sel] & keep_vec[sel]) |
                   (req_addr[ADDR_W-1 -: HI_W] & ~keep_vec[sel]);

  always_comb begin
    xaddr = {hi_part, req_addr[GRAN_W-1:0]};
    if (!mlow_vec[sel]) xaddr[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
      rsp_type  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_hit;
      rsp_win   <= any_hit ? sel : '0;
      rsp_addr  <= any_hit ? xaddr : '0;
      rsp_type  <= any_hit ? mty_vec[sel] : '0;
    end
  end

  function automatic logic [NUM_WIN-1:0] below(input logic [WIN_W-1:0] w);
    logic [NUM_WIN-1:0] m;
    for (int i = 0; i < NUM_WIN; i++) m[i] = (i < int'(w));
    return m;
  endfunction

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_addr[GRAN_W-1:2] == $past(req_addr[GRAN_W-1:2]));
  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (($past(match_vec) & below(rsp_win)) == '0));
  assert_enabled_only_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> ((($past(en_vec) >> rsp_win) & NUM_WIN'(1)) != '0));
  assert_low_bits_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && rsp_addr[1:0] != 2'b00) |-> rsp_addr[1:0] == $past(req_addr[1:0]));
  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_type == '0 && rsp_win == '0));
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
  import xlat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_WIN     = 3,
  parameter int GRAN_W      = 20,
  parameter int IO_WIN      = NUM_WIN - 1,
  parameter int IO_SZ_CODE  = 4,
  parameter int WIN_W       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIN_W-1:0]  wr_win,
  input  logic              wr_map,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [TY_W-1:0]   rsp_type
);
  localparam int HI_W = ADDR_W - GRAN_W;

  logic [NUM_WIN-1:0]           en_v, mlow_v, match_v;
  logic [NUM_WIN-1:0][SZ_W-1:0] sz_v;
  logic [NUM_WIN-1:0][HI_W-1:0] base_v, mhi_v, keep_v;
  logic [NUM_WIN-1:0][TY_W-1:0] mty_v;

  xlat_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .GRAN_W(GRAN_W), .WIN_W(WIN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_map(wr_map),
    .wr_data(wr_data), .en_o(en_v), .sz_o(sz_v), .base_o(base_v),
    .mhi_o(mhi_v), .mty_o(mty_v), .mlow_o(mlow_v)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    xlat_match #(
      .ADDR_W(ADDR_W), .GRAN_W(GRAN_W),
      .FIXED(i == IO_WIN), .FIXED_CODE(IO_SZ_CODE)
    ) u_match (
      .en(en_v[i]), .sz(sz_v[i]), .base_hi(base_v[i]), .addr(req_addr),
      .hit(match_v[i]), .keep_mask(keep_v[i])
    );
  end

  xlat_pick #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .GRAN_W(GRAN_W), .WIN_W(WIN_W)) u_pick (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .match_vec(match_v), .en_vec(en_v), .keep_vec(keep_v), .mhi_vec(mhi_v),
    .mty_vec(mty_v), .mlow_vec(mlow_v), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_type(rsp_type)
  );
endmodule

// File: tb/sim_addr_window_xlat.sv
`timescale 1ns/1ps
module sim_addr_window_xlat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_map = 1'b0, req_valid = 1'b0;
  logic [1:0]  wr_win = '0;
  logic [31:0] wr_data = '0, req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_type;

  always #4 clk = ~clk;

  addr_window_xlat u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_map(wr_map),
    .wr_data(wr_data), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_addr(rsp_addr), .rsp_type(rsp_type)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_en [3];
  logic [3:0]  m_sz [3];
  logic [11:0] m_base [3];
  logic [11:0] m_mhi [3];
  logic [2:0]  m_ty [3];
  logic        m_low [3];

  logic [37:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [37:0] model(input logic [31:0] a);
    for (int i = 0; i < 3; i++) begin
      logic [3:0]  c;
      logic [11:0] keep;
      logic [31:0] x;
      c = (i == 2) ? 4'd4 : m_sz[i];
      keep = (c >= 12) ? 12'h000 : ~((12'h1 << c) - 12'h1);
      if (m_en[i] && ((a[31:20] & keep) == (m_base[i] & keep))) begin
        x = {(m_mhi[i] & keep) | (a[31:20] & ~keep), a[19:0]};
        if (!m_low[i]) x[1:0] = 2'b00;
        return {1'b1, 2'(i), x, m_ty[i]};
      end
    end
    return '0;
  endfunction

  task automatic put_inputs(input logic we, input logic [1:0] w, input logic mp,
                            input logic [31:0] d, input logic rv, input logic [31:0] a);
    @(negedge clk);
    wr_en = we; wr_win = w; wr_map = mp; wr_data = d; req_valid = rv; req_addr = a;
  endtask

  task automatic apply_write(input logic [1:0] w, input logic mp, input logic [31:0] d);
    if (mp) begin
      m_mhi[w] = d[31:20]; m_ty[w] = d[3:1]; m_low[w] = d[0];
    end else begin
      m_base[w] = d[31:20]; m_sz[w] = d[7:4]; m_en[w] = d[0];
    end
  endtask

  task automatic wr_reg(input logic [1:0] w, input logic mp, input logic [31:0] d);
    put_inputs(1'b1, w, mp, d, 1'b0, '0);
    apply_write(w, mp, d);
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    put_inputs(1'b0, '0, 1'b0, '0, 1'b1, a);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic lookup_with_write(input logic [31:0] a, input logic [1:0] w,
                                   input logic mp, input logic [31:0] d, input string tag);
    put_inputs(1'b1, w, mp, d, 1'b1, a);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    apply_write(w, mp, d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put_inputs(1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      logic [37:0] got, exp;
      string t;
      got = {rsp_hit, rsp_win, rsp_addr, rsp_type};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result: actual %h expected none", got);
      end else begin
        exp = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s hit/win/addr/type: actual %h expected %h", t, got, exp);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_en[i] = 0; m_sz[i] = 0; m_base[i] = 0; m_mhi[i] = 0; m_ty[i] = 0; m_low[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rsp_valid after reset: actual %b expected 0", rsp_valid);
    end
    lookup(32'h4000_0000, "R1");
    lookup(32'h0000_0000, "R9");

    wr_reg(2'd0, 1'b0, 32'h4000_0081);
    wr_reg(2'd0, 1'b1, 32'h0000_0006);
    wr_reg(2'd1, 1'b0, 32'h5000_0081);
    wr_reg(2'd1, 1'b1, 32'h1000_000E);
    wr_reg(2'd2, 1'b0, 32'h6000_0091);
    wr_reg(2'd2, 1'b1, 32'h0000_0003);

    lookup(32'h4123_4567, "R8");
    lookup(32'h5ABC_DEF3, "R2");
    lookup(32'h60FF_FFFF, "R7");
    lookup(32'h6100_0000, "R6");
    lookup(32'h3FFF_FFFF, "R9");
    lookup(32'h4FFF_FFFC, "R5");
    lookup(32'h5FFF_FFFF, "R5");
    idle(1);

    wr_reg(2'd0, 1'b0, 32'h4000_0091);
    lookup(32'h5000_0010, "R3");
    wr_reg(2'd1, 1'b0, 32'h6100_0041);
    wr_reg(2'd1, 1'b1, 32'h0000_000A);
    lookup(32'h6100_0808, "R7");
    lookup(32'h6000_0123, "R3");
    lookup(32'h6200_0000, "R9");

    lookup_with_write(32'h4000_0100, 2'd0, 1'b0, 32'h4000_0090, "R10");
    lookup(32'h4000_0100, "R4");
    lookup(32'h5000_0000, "R4");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 missing results: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule